// File: doc/BRIEF.md
# Chip-Select Wait-State and Ready Controller

This block paces one bus cycle at a time through four base states, T1, T2, T3 and T4. Between T3 and T4 it can insert wait states. Each cycle targets one of several chip-select regions. Every region owns a small control register with two fields: a flag that makes the cycle ignore external ready, and a wait code. Ordinary regions decode a two-bit code. One peripheral region decodes a three-bit code whose upper values jump to longer, non-linear wait counts.

When a region requires ready, its programmed waits always run to the end before external ready can close or stretch the cycle. Ready is the OR of a synchronous input and an asynchronous input, and the asynchronous input first passes through a flop synchronizer. If ready is missing at the sampling point, the cycle keeps stretching. Once ready is seen, exactly one more wait follows, then T4. Two DRAM-enable inputs force ready to be ignored for the upper and lower memory regions. A region stays inactive until software writes its register. A register read does not activate it.

A cycle is requested with a one-clock start strobe and a region number. The block reports the current bus state, a wait flag, a done pulse in T4, and a one-hot chip-select vector.

Top module: `csel_wait_ctrl`

## Requirements
- R1: After reset the bus state is idle (code 0), done, wait and every chip select are low, and every region is unwritten with a read-back value of 0.
- R2: A start seen in idle gives T1 on the next clock. The sequence is then T1, T2, T3, zero or more waits, T4, idle. The state codes are idle=0, T1=1, T2=2, T3=3, wait=4, T4=5. Done is high exactly in T4 and wait is high exactly in the wait state. A start seen outside idle is ignored.
- R3: A write sets ignore-ready from data bit 3 and the wait code from bits 2:0. When ignore-ready is 1, the cycle inserts exactly the decoded wait count, whatever the ready inputs do.
- R4: An ordinary region decodes only code bits 1:0, giving 0 to 3 waits. Bit 2 is dropped on write.
- R5: The peripheral region (index 4 by default) maps codes 0, 1, 2, 3, 4, 5, 6, 7 to 0, 1, 2, 3, 5, 7, 9, 15 waits.
- R6: When ready is required, ready is sampled in the second-to-last programmed wait. With 0 or 1 programmed waits it is sampled in T3. If ready is high there, the cycle lasts 4 plus the wait count clocks.
- R7: If ready is low at the sampling point, waits continue until ready is seen. One further wait follows, then T4. With T1 as clock 0 and ready first seen at clock r, the cycle lasts r+3 clocks.
- R8: dram_en bit 1 forces ready-ignore for region 0 (upper) and dram_en bit 0 for region 1 (lower), whatever the register's ignore-ready bit holds.
- R9: The effective ready is srdy OR the synchronized async ready. The async input reaches the decision two clocks after it is sampled high.
- R10: A region that has never been written drives no chip select. A cycle to it runs with 0 waits and ignores ready. Reading its register does not change this.
- R11: During T1 to T4 of a cycle to a written region, exactly that region's cs_act bit is high. All bits are low in idle.
- R12: A read strobe returns {ignore-ready, stored code} of the addressed region on cfg_rdata one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_idx | input | IDX_W | Register region index |
| cfg_wdata | input | 4 | Write data: bit 3 ignore-ready, bits 2:0 wait code |
| cfg_rdata | output | 4 | Read-back data |
| cyc_start | input | 1 | Bus-cycle start strobe |
| cyc_sel | input | IDX_W | Region of the requested cycle |
| dram_en | input | 2 | DRAM mode: bit 1 upper region, bit 0 lower region |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready, active high |
| bus_state | output | 3 | Current bus state code |
| bus_wait | output | 1 | High during a wait state |
| cyc_done | output | 1 | High during T4 |
| cs_act | output | N_REGION | Active-high chip selects |

## Verification
A wrong wait counter or a sampling point in the wrong wait changes the length of the cycle. The error is visible at the clock on which T4 appears: one clock early or late against a count computed from the code and the ready timing. A stuck stretch flag either hangs the cycle in waits or skips the one trailing wait after ready. A bad synchronizer depth shifts every async-ready cycle by whole clocks. A wrong activation flag shows as a chip select pulsing, or staying silent, for the whole cycle. The bench therefore sweeps each code against each ready arrival clock and compares cycle lengths exactly.

// File: rtl/csw_pkg.sv
package csw_pkg;

   typedef enum logic [2:0] {
      BS_IDLE = 3'd0,
      BS_T1   = 3'd1,
      BS_T2   = 3'd2,
      BS_T3   = 3'd3,
      BS_TW   = 3'd4,
      BS_T4   = 3'd5
   } bus_st_e;

   localparam int CODE_W = 3;
   localparam int WAIT_W = 4;

   // extended peripheral code: linear below 4, then 5, 7, 9, 15
   function automatic logic [WAIT_W-1:0] peri_waits(input logic [CODE_W-1:0] c);
      logic [WAIT_W-1:0] w;
      case (c)
         3'd4:    w = 4'd5;
         3'd5:    w = 4'd7;
         3'd6:    w = 4'd9;
         3'd7:    w = 4'd15;
         default: w = {1'b0, c};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("csw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/csw_cfg_bank.sv
module csw_cfg_bank #(
   parameter int N_REGION = 5,
   parameter int PERI_IDX = 4,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             re,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       wdata,
   output logic [3:0]       rdata,
   input  logic [IDX_W-1:0] sel,
   output logic             sel_on,
   output logic             sel_ign,
   output logic [csw_pkg::WAIT_W-1:0] sel_waits
);
   import csw_pkg::*;

   logic [N_REGION-1:0]                  on_v;
   logic [N_REGION-1:0]                  ign_v;
   logic [N_REGION-1:0][CODE_W-1:0]      code_v;
   logic [N_REGION-1:0][WAIT_W-1:0]      wt_v;

   for (genvar i = 0; i < N_REGION; i++) begin : g_reg
      localparam logic [CODE_W-1:0] CMASK = (i == PERI_IDX) ? 3'b111 : 3'b011;
      logic             on_q;
      logic             ign_q;
      logic [CODE_W-1:0] code_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on_q   <= 1'b0;
            ign_q  <= 1'b0;
            code_q <= '0;
         end else if (we && (idx == IDX_W'(i))) begin
            on_q   <= 1'b1;
            ign_q  <= wdata[3];
            code_q <= wdata[CODE_W-1:0] & CMASK;
         end
      end

      if (i == PERI_IDX) begin : g_peri
         assign wt_v[i] = peri_waits(code_q);
      end else begin : g_plain
         assign wt_v[i] = {2'b00, code_q[1:0]};
      end

      assign on_v[i]   = on_q;
      assign ign_v[i]  = ign_q;
      assign code_v[i] = code_q;
   end

   logic idx_ok;
   logic sel_ok;
   assign idx_ok = (int'(idx) < N_REGION);
   assign sel_ok = (int'(sel) < N_REGION);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rdata <= '0;
      else if (re && idx_ok)   rdata <= {ign_v[idx], code_v[idx]};
      else if (re)             rdata <= '0;
   end

   assign sel_on    = sel_ok && on_v[sel];
   assign sel_ign   = sel_ok && ign_v[sel];
   assign sel_waits = sel_ok ? wt_v[sel] : '0;
endmodule

// File: rtl/csw_seq.sv
module csw_seq #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ign,
   input  logic [WAIT_W-1:0] waits,
   input  logic              ready,
   output csw_pkg::bus_st_e  state,
   output logic [WAIT_W-1:0] lat_waits,
   output logic              lat_ign
);
   import csw_pkg::*;

   localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);
   localparam logic [WAIT_W-1:0] TWO = WAIT_W'(2);

   logic [WAIT_W-1:0] cnt_q;
   logic              stretch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= BS_IDLE;
         cnt_q     <= '0;
         stretch_q <= 1'b0;
         lat_waits <= '0;
         lat_ign   <= 1'b0;
      end else begin
         case (state)
            BS_IDLE: if (start) begin
               state     <= BS_T1;
               lat_waits <= waits;
               lat_ign   <= ign;
               stretch_q <= 1'b0;
            end
            BS_T1: state <= BS_T2;
            BS_T2: state <= BS_T3;
            BS_T3: begin
               if (!lat_ign && (lat_waits <= ONE)) begin
                  // short programs sample ready in T3
                  if (!ready) begin
                     state     <= BS_TW;
                     stretch_q <= 1'b1;
                  end else if (lat_waits == '0) begin
                     state <= BS_T4;
                  end else begin
                     state <= BS_TW;
                     cnt_q <= ONE;
                  end
               end else if (lat_waits == '0) begin
                  state <= BS_T4;
               end else begin
                  state <= BS_TW;
                  cnt_q <= lat_waits;
               end
            end
            BS_TW: begin
               if (stretch_q) begin
                  if (ready) begin
                     stretch_q <= 1'b0;
                     cnt_q     <= ONE;
                  end
               end else if (!lat_ign && (cnt_q == TWO) && !ready) begin
                  stretch_q <= 1'b1;
               end else if (cnt_q == ONE) begin
                  state <= BS_T4;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            BS_T4:   state <= BS_IDLE;
            default: state <= BS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/csel_wait_ctrl.sv
module csel_wait_ctrl #(
   parameter int N_REGION    = 5,
   parameter int PERI_IDX    = 4,
   parameter int UPPER_IDX   = 0,
   parameter int LOWER_IDX   = 1,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(N_REGION)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_re,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [3:0]          cfg_wdata,
   output logic [3:0]          cfg_rdata,
   input  logic                cyc_start,
   input  logic [IDX_W-1:0]    cyc_sel,
   input  logic [1:0]          dram_en,
   input  logic                srdy,
   input  logic                ardy,
   output logic [2:0]          bus_state,
   output logic                bus_wait,
   output logic                cyc_done,
   output logic [N_REGION-1:0] cs_act
);
   import csw_pkg::*;

   if (N_REGION < 2) begin : g_bad_n
      $error("csel_wait_ctrl: N_REGION must be at least 2");
   end
   if (PERI_IDX >= N_REGION || UPPER_IDX >= N_REGION || LOWER_IDX >= N_REGION) begin : g_bad_idx
      $error("csel_wait_ctrl: region index parameter out of range");
   end
   if (UPPER_IDX == LOWER_IDX) begin : g_bad_mem
      $error("csel_wait_ctrl: upper and lower regions must differ");
   end

   logic              sel_on;
   logic              sel_ign;
   logic [WAIT_W-1:0] sel_waits;
   logic              ardy_s;
   logic              rdy_eff;
   logic              dram_hit;
   logic              ign_eff;
   logic [WAIT_W-1:0] waits_eff;
   bus_st_e           st;
   logic [WAIT_W-1:0] lat_waits;
   logic              lat_ign;
   logic [IDX_W-1:0]  lat_sel;
   logic              lat_on;
   logic              accept;

   csw_cfg_bank #(
      .N_REGION (N_REGION),
      .PERI_IDX (PERI_IDX),
      .IDX_W    (IDX_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .re        (cfg_re),
      .idx       (cfg_idx),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .sel       (cyc_sel),
      .sel_on    (sel_on),
      .sel_ign   (sel_ign),
      .sel_waits (sel_waits)
   );

   csw_sync #(.STAGES(SYNC_STAGES)) u_async_rdy (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ardy),
      .q     (ardy_s)
   );

   assign rdy_eff   = srdy | ardy_s;
   assign dram_hit  = ((cyc_sel == IDX_W'(UPPER_IDX)) && dram_en[1]) ||
                      ((cyc_sel == IDX_W'(LOWER_IDX)) && dram_en[0]);
   assign ign_eff   = !sel_on || sel_ign || dram_hit;
   assign waits_eff = sel_on ? sel_waits : '0;
   assign accept    = cyc_start && (st == BS_IDLE);

   csw_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cyc_start),
      .ign       (ign_eff),
      .waits     (waits_eff),
      .ready     (rdy_eff),
      .state     (st),
      .lat_waits (lat_waits),
      .lat_ign   (lat_ign)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_sel <= '0;
         lat_on  <= 1'b0;
      end else if (accept) begin
         lat_sel <= cyc_sel;
         lat_on  <= sel_on;
      end
   end

   for (genvar i = 0; i < N_REGION; i++) begin : g_cs
      assign cs_act[i] = lat_on && (lat_sel == IDX_W'(i)) && (st != BS_IDLE);
   end

   assign bus_state = st;
   assign bus_wait  = (st == BS_TW);
   assign cyc_done  = (st == BS_T4);
endmodule

// File: rtl/csel_wait_ctrl_chk.sv
module csel_wait_ctrl_chk #(
   parameter int N_REGION = 5,
   parameter int IDX_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [IDX_W-1:0]    cfg_idx,
   input logic                cyc_start,
   input logic [2:0]          bus_state,
   input logic                bus_wait,
   input logic                cyc_done,
   input logic [N_REGION-1:0] cs_act,
   input logic [3:0]          lat_waits,
   input logic                lat_ign
);
   localparam logic [2:0] S_IDLE = 3'd0;
   localparam logic [2:0] S_T1   = 3'd1;
   localparam logic [2:0] S_T2   = 3'd2;
   localparam logic [2:0] S_T3   = 3'd3;
   localparam logic [2:0] S_TW   = 3'd4;
   localparam logic [2:0] S_T4   = 3'd5;

   logic [7:0]          twc;
   logic [N_REGION-1:0] wr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             twc <= '0;
      else if (bus_state == S_T1)             twc <= '0;
      else if (bus_wait && twc != 8'hff)      twc <= twc + 8'd1;
   end

   for (genvar i = 0; i < N_REGION; i++) begin : g_seen
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  wr_seen[i] <= 1'b0;
         else if (cfg_we && cfg_idx == IDX_W'(i))     wr_seen[i] <= 1'b1;
      end
   end

   p_start_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == S_IDLE && cyc_start) |=> (bus_state == S_T1));

   p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == S_T2) |=> (bus_state == S_T3));

   p_done_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> (bus_state == S_IDLE));

   p_wait_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wait) |-> ($past(bus_state) == S_T3));

   p_waits_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == S_T4) |-> (twc >= {4'd0, lat_waits}));

   p_ign_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == S_T4 && lat_ign) |-> (twc == {4'd0, lat_waits}));

   p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));

   p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == S_IDLE) |-> (cs_act == '0));

   p_cs_unwritten_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs_act & ~wr_seen) == '0));
endmodule

bind csel_wait_ctrl csel_wait_ctrl_chk #(
   .N_REGION (N_REGION),
   .IDX_W    (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_idx   (cfg_idx),
   .cyc_start (cyc_start),
   .bus_state (bus_state),
   .bus_wait  (bus_wait),
   .cyc_done  (cyc_done),
   .cs_act    (cs_act),
   .lat_waits (lat_waits),
   .lat_ign   (lat_ign)
);

// File: tb/csel_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module csel_wait_ctrl_tb_top;
   localparam int N     = 5;
   localparam int PERI  = 4;
   localparam int IW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_re = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [3:0]    cfg_wdata = '0;
   logic [3:0]    cfg_rdata;
   logic          cyc_start = 1'b0;
   logic [IW-1:0] cyc_sel = '0;
   logic [1:0]    dram_en = '0;
   logic          srdy = 1'b0, ardy = 1'b0;
   logic [2:0]    bus_state;
   logic          bus_wait, cyc_done;
   logic [N-1:0]  cs_act;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   bit shadow_on[N];
   bit shadow_ign[N];
   int shadow_code[N];

   always #2 clk = ~clk;

   csel_wait_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cyc_start(cyc_start), .cyc_sel(cyc_sel), .dram_en(dram_en),
      .srdy(srdy), .ardy(ardy), .bus_state(bus_state), .bus_wait(bus_wait),
      .cyc_done(cyc_done), .cs_act(cs_act)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int bw(input int ri, input int code);
      if (ri != PERI) return code % 4;
      if (code < 4) return code;
      if (code == 7) return 15;
      return 2 * code - 3;   // 4->5, 5->7, 6->9
   endfunction

   task automatic wr(input int ri, input bit ign, input int code);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(ri); cfg_wdata = {ign, 3'(code)};
      @(negedge clk);
      cfg_we = 1'b0;
      shadow_on[ri] = 1; shadow_ign[ri] = ign; shadow_code[ri] = code;
   endtask

   task automatic rd(input int ri, input int exp, input string req);
      @(negedge clk);
      cfg_re = 1'b1; cfg_idx = IW'(ri);
      @(negedge clk);
      cfg_re = 1'b0;
      chk(cfg_rdata == 4'(exp), req, int'(cfg_rdata), exp);
   endtask

   task automatic run(input int ri, input int c_r, input int c_a, input bit poke, input string tag);
      int nw, s, r, expt, k, got;
      bit on, ign, dram, cs_bad, flag_bad;
      logic [N-1:0] cs_exp;
      on   = shadow_on[ri];
      nw   = on ? bw(ri, shadow_code[ri]) : 0;
      dram = (ri == 0 && dram_en[1]) || (ri == 1 && dram_en[0]);
      ign  = !on || shadow_ign[ri] || dram;
      if (ign) expt = 4 + nw;
      else begin
         s = (nw >= 2) ? nw + 1 : 2;
         r = (c_r < c_a + 2) ? c_r : c_a + 2;   // R9: async seen two clocks later
         if (r < s) r = s;
         expt = (nw == 0 && r == 2) ? 4 : r + 3;
      end
      cs_exp = on ? (N'(1) << ri) : '0;
      @(negedge clk);
      cyc_sel = IW'(ri); cyc_start = 1'b1; srdy = 1'b0; ardy = 1'b0;
      @(negedge clk);
      cyc_start = 1'b0;
      chk(bus_state == 3'd1, "R2 T1 after start", int'(bus_state), 1);
      k = 0; got = -1; cs_bad = 0; flag_bad = 0;
      while (k < 100 && got < 0) begin
         srdy = (k >= c_r);
         ardy = (k >= c_a);
         if (poke) begin
            cyc_start = (k == 1);
            cyc_sel   = IW'((ri + 1) % N);
         end
         if (cs_act !== cs_exp) cs_bad = 1;
         if (cyc_done !== (bus_state == 3'd5)) flag_bad = 1;
         if (bus_wait !== (bus_state == 3'd4)) flag_bad = 1;
         if (bus_state == 3'd5) got = k + 1;
         else begin
            @(negedge clk);
            k++;
         end
      end
      srdy = 1'b0; ardy = 1'b0; cyc_start = 1'b0;
      chk(got == expt, tag, got, expt);
      chk(!cs_bad, on ? "R11 chip select" : "R10 chip select", int'(cs_act), int'(cs_exp));
      chk(!flag_bad, "R2 done/wait flags", int'(bus_state), 0);
      @(negedge clk);
      chk(bus_state == 3'd0, "R2 idle after T4", int'(bus_state), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         shadow_on[i] = 0; shadow_ign[i] = 0; shadow_code[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(bus_state == 3'd0, "R1 state", int'(bus_state), 0);
      chk(!cyc_done && !bus_wait, "R1 done/wait", int'({cyc_done, bus_wait}), 0);
      chk(cs_act == '0, "R1 cs", int'(cs_act), 0);
      rd(3, 0, "R1 readback");

      // R10: unwritten region, a read does not enable it
      run(3, 99, 99, 0, "R10 unwritten length");
      run(2, 99, 99, 0, "R10 unwritten length");

      // R3 R4 R5: ignore-ready sweep, ready held low
      for (int ri = 0; ri < N; ri++)
         for (int c = 0; c < 8; c++) begin
            wr(ri, 1'b1, c);
            run(ri, 99, 99, 0, ri == PERI ? "R5 peri decode (R3)" : "R4 plain decode (R3)");
         end

      // R12 readback, R4 bit 2 dropped
      wr(4, 1'b1, 5);
      rd(4, 13, "R12 peri readback");
      wr(2, 1'b0, 7);
      rd(2, 3, "R4 bit2 dropped (R12)");

      // R6: ready required, ready high throughout
      for (int ri = 0; ri < N; ri++)
         for (int c = 0; c < 8; c++) begin
            wr(ri, 1'b0, c);
            run(ri, 0, 99, 0, "R6 ready at sample");
         end

      // R7: stretch sweep on sync ready
      for (int c = 0; c < 8; c++) begin
         wr(4, 1'b0, c);
         for (int cr = 0; cr < 19; cr++) run(4, cr, 99, 0, "R7 stretch peri");
      end
      for (int c = 0; c < 4; c++) begin
         wr(2, 1'b0, c);
         for (int cr = 0; cr < 9; cr++) run(2, cr, 99, 0, "R7 stretch plain");
      end

      // R9: async ready through synchronizer
      for (int c = 0; c < 8; c++) begin
         wr(4, 1'b0, c);
         for (int ca = 0; ca < 15; ca++) run(4, 99, ca, 0, "R9 async ready");
      end

      // R8: DRAM override ignores ready
      dram_en = 2'b01;
      wr(1, 1'b0, 2);
      run(1, 99, 99, 0, "R8 lower dram override");
      dram_en = 2'b10;
      wr(0, 1'b0, 5);
      run(0, 99, 99, 0, "R8 upper dram override");
      dram_en = 2'b00;

      // R2: start while busy ignored
      wr(4, 1'b1, 4);
      run(4, 99, 99, 1, "R2 busy start ignored");

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule